// File: doc/BRIEF.md
# Embedded Trigger-and-Capture Logic Analyzer

This block is a logic analyzer that sits inside the chip. After it is armed, it samples a probe bus of parameterized width on every rising edge of the system clock and writes each sample into an inferred on-chip memory that it uses as a circular buffer. Because it only samples at clock edges, it cannot show clock waveforms. A programmable number of samples taken before the trigger is kept. The trigger is the logical AND of two masked pattern comparators. It can be set to fire only on the Nth cycle in which that combined condition holds.

Control is a set of level configuration inputs and an arm strobe. When capture ends, a done flag rises. The physical buffer address of the trigger sample is exposed. The stored window is read through an address/data port whose addresses are rotated, so that address 0 is the oldest sample of the window.

Top module: `probe_recorder`

## Requirements
- R1: After reset, `done` is 0 and `state_o` is 0 (idle). The state codes are 0 idle, 1 pre-fill, 2 trigger hunt, 3 post-trigger, 4 done.
- R2: `arm` is accepted only in idle or done. An accepted `arm` clears the occurrence count and the write pointer and latches `pre_count` and `occ_count`. An `arm` seen during pre-fill, hunt or post-trigger has no effect on the capture.
- R3: From the cycle after arming until capture ends, exactly one probe sample is written per clock, at consecutive buffer addresses that start at 0 and wrap modulo DEPTH.
- R4: A comparator hits when `((probe ^ val) & care) == 0`. An all-zero care mask always hits.
- R5: The trigger condition is the AND of both comparators in the same cycle.
- R6: The trigger fires on the `occ_count`-th cycle in hunt state in which the condition holds. A count of 0 behaves as 1.
- R7: Conditions during the first `pre_count` samples after arming (pre-fill) are neither counted nor able to trigger.
- R8: The stored window is `pre_count` samples before the trigger sample, the trigger sample itself, and DEPTH−`pre_count`−1 samples after it. `done` rises on the clock edge that writes the last sample.
- R9: `rd_data` returns, one clock after `rd_addr` is presented, window sample number `rd_addr`, where 0 is the oldest.
- R10: `trig_addr` equals the physical buffer address of the trigger sample, which is the sample index since arming modulo DEPTH.
- R11: `pre_count` values of 0 and DEPTH−1 both give a correct window. With 0, the trigger sample is read at address 0.
- R12: Once done, probe activity writes nothing and leaves the stored window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start-capture strobe |
| pre_count | input | AW | Samples kept before the trigger (0..DEPTH−1) |
| occ_count | input | CNT_W | Required condition occurrences (0 treated as 1) |
| match_a_val | input | PROBE_W | Comparator A pattern |
| match_a_care | input | PROBE_W | Comparator A mask (1 = compare bit) |
| match_b_val | input | PROBE_W | Comparator B pattern |
| match_b_care | input | PROBE_W | Comparator B mask |
| probe | input | PROBE_W | Sampled signals |
| rd_addr | input | AW | Rotated readback address |
| rd_data | output | PROBE_W | Readback sample, one-cycle latency |
| done | output | 1 | Capture complete |
| trig_addr | output | AW | Physical address of the trigger sample |
| state_o | output | 3 | Controller state code |

## Verification
The assertions assume that `arm` is a single-cycle strobe driven from synchronous logic. They also assume that `pre_count` never exceeds DEPTH−1 and that DEPTH is a power of two, so that pointer wrap and window arithmetic are plain modulo operations. The stimulus drives every input half a cycle away from the sampling edge and keeps `pre_count` within 0..DEPTH−1. It re-arms only from done, except for one deliberate strobe during the post-trigger phase. It puts a distinct, monotonically increasing value on the probe in every sampled cycle, so that any misplaced or extra write shows up in the readback.

// File: rtl/probe_rec_pkg.sv
package probe_rec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FILL = 3'd1,
        ST_HUNT = 3'd2,
        ST_POST = 3'd3,
        ST_DONE = 3'd4
    } cap_state_e;
endpackage

// File: rtl/probe_match.sv
// Masked equality comparator: hit when every cared-for bit equals the pattern.
module probe_match #(
    parameter int W = 32
) (
    input  logic [W-1:0] probe,
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] care,
    output logic         hit
);
    assign hit = ~|((probe ^ ref_val) & care);
endmodule

// File: rtl/sample_ram.sv
// Simple dual-port sample store, registered read.
module sample_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/capture_ctrl.sv
// Arm / pre-fill / hunt / post-capture sequencer.
module capture_ctrl
    import probe_rec_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [AW-1:0]    pre_cfg,
    input  logic [CNT_W-1:0] occ_cfg,
    input  logic             trig_hit,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [AW-1:0]    trig_addr,
    output logic [AW-1:0]    win_base,
    output logic             done,
    output logic [2:0]       state
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        cap_state_e       st;
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    fill;
        logic [AW-1:0]    post_left;
        logic [CNT_W-1:0] occ;
        logic [CNT_W-1:0] goal;
        logic [AW-1:0]    pre;
        logic [AW-1:0]    trig;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  we_d;

    always_comb begin
        r_d  = r_q;
        we_d = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (arm) begin
                    r_d.st     = (pre_cfg == '0) ? ST_HUNT : ST_FILL;
                    r_d.wr_ptr = '0;
                    r_d.fill   = '0;
                    r_d.occ    = '0;
                    r_d.pre    = pre_cfg;
                    r_d.goal   = (occ_cfg == '0) ? CNT_W'(1) : occ_cfg;
                end
            end
            ST_FILL: begin
                we_d       = 1'b1;
                r_d.wr_ptr = r_q.wr_ptr + 1'b1;
                r_d.fill   = r_q.fill + 1'b1;
                if (AW'(r_q.fill + 1'b1) == r_q.pre) r_d.st = ST_HUNT;
            end
            ST_HUNT: begin
                we_d       = 1'b1;
                r_d.wr_ptr = r_q.wr_ptr + 1'b1;
                if (trig_hit) begin
                    r_d.occ = r_q.occ + 1'b1;
                    if (CNT_W'(r_q.occ + 1'b1) >= r_q.goal) begin
                        r_d.trig      = r_q.wr_ptr;
                        r_d.post_left = LAST - r_q.pre;
                        r_d.st        = ((LAST - r_q.pre) == '0) ? ST_DONE : ST_POST;
                    end
                end
            end
            ST_POST: begin
                we_d          = 1'b1;
                r_d.wr_ptr    = r_q.wr_ptr + 1'b1;
                r_d.post_left = r_q.post_left - 1'b1;
                if (r_q.post_left == AW'(1)) r_d.st = ST_DONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign we        = we_d;
    assign waddr     = r_q.wr_ptr;
    assign trig_addr = r_q.trig;
    assign win_base  = r_q.trig - r_q.pre;
    assign done      = (r_q.st == ST_DONE);
    assign state     = r_q.st;

    // Each capturing cycle advances the write pointer by exactly one.
    assert_wr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FILL || r_q.st == ST_HUNT || r_q.st == ST_POST)
        |=> (r_q.wr_ptr == AW'($past(r_q.wr_ptr) + 1'b1)));

    // Pre-fill can never record a trigger position.
    assert_fill_no_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FILL) |=> $stable(r_q.trig));

    // Post-capture runs to completion; an arm strobe cannot leave it early.
    assert_post_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_POST) |=> (r_q.st == ST_POST || r_q.st == ST_DONE));

    // Arm during hunt is ignored: the capture keeps going.
    assert_arm_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HUNT && arm) |=> (r_q.st != ST_IDLE && r_q.st != ST_FILL));

    // Done without arm keeps the buffer frozen.
    assert_hold_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE && !arm) |=> ($stable(r_q.wr_ptr) && r_q.st == ST_DONE));
endmodule

// File: rtl/probe_recorder.sv
module probe_recorder
    import probe_rec_pkg::*;
#(
    parameter int PROBE_W = 32,
    parameter int DEPTH   = 64,
    parameter int CNT_W   = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int N_CMP  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [AW-1:0]      pre_count,
    input  logic [CNT_W-1:0]   occ_count,
    input  logic [PROBE_W-1:0] match_a_val,
    input  logic [PROBE_W-1:0] match_a_care,
    input  logic [PROBE_W-1:0] match_b_val,
    input  logic [PROBE_W-1:0] match_b_care,
    input  logic [PROBE_W-1:0] probe,
    input  logic [AW-1:0]      rd_addr,
    output logic [PROBE_W-1:0] rd_data,
    output logic               done,
    output logic [AW-1:0]      trig_addr,
    output logic [2:0]         state_o
);
    logic [PROBE_W-1:0] cmp_val  [N_CMP];
    logic [PROBE_W-1:0] cmp_care [N_CMP];
    logic [N_CMP-1:0]   cmp_hit;
    logic               we;
    logic [AW-1:0]      waddr, win_base, raddr;

    assign cmp_val[0]  = match_a_val;
    assign cmp_care[0] = match_a_care;
    assign cmp_val[1]  = match_b_val;
    assign cmp_care[1] = match_b_care;

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        probe_match #(.W(PROBE_W)) u_match (
            .probe   (probe),
            .ref_val (cmp_val[g]),
            .care    (cmp_care[g]),
            .hit     (cmp_hit[g])
        );
    end

    capture_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .pre_cfg   (pre_count),
        .occ_cfg   (occ_count),
        .trig_hit  (&cmp_hit),
        .we        (we),
        .waddr     (waddr),
        .trig_addr (trig_addr),
        .win_base  (win_base),
        .done      (done),
        .state     (state_o)
    );

    assign raddr = win_base + rd_addr;

    sample_ram #(.W(PROBE_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (probe),
        .raddr (raddr),
        .rdata (rd_data)
    );

    // With both care masks zero the trigger condition must be true.
    always_comb begin
        if (match_a_care == '0 && match_b_care == '0)
            assert_zero_mask_hit_R4: assert (&cmp_hit);
    end
endmodule

// File: tb/sim_probe_recorder.sv
`timescale 1ns/1ps
module sim_probe_recorder;
    localparam int W = 16;
    localparam int D = 16;
    localparam int AW = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic [AW-1:0] pre_count = '0;
    logic [CW-1:0] occ_count = '0;
    logic [W-1:0] va = '0, ma = '0, vb = '0, mb = '0, probe = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0] rd_data;
    logic done;
    logic [AW-1:0] trig_addr;
    logic [2:0] state_o;

    int checks = 0;
    int fails = 0;
    logic rd_req = 1'b0;
    logic rd_v = 1'b0;
    logic [W-1:0] exp_q [$];
    string cur_tag = "R9";

    always #4 clk = ~clk;

    probe_recorder #(.PROBE_W(W), .DEPTH(D), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .pre_count(pre_count), .occ_count(occ_count),
        .match_a_val(va), .match_a_care(ma), .match_b_val(vb), .match_b_care(mb),
        .probe(probe), .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
        .trig_addr(trig_addr), .state_o(state_o)
    );

    function automatic logic [W-1:0] f(int k);
        return W'(16'h1000 + k);
    endfunction

    function automatic int model_kt(int pre, int goal, logic [W-1:0] a_v, logic [W-1:0] a_m,
                                    logic [W-1:0] b_v, logic [W-1:0] b_m);
        int g = (goal == 0) ? 1 : goal;
        int c = 0;
        for (int k = pre; k < 200; k++) begin
            logic [W-1:0] p;
            p = f(k);
            if ((((p ^ a_v) & a_m) == '0) && (((p ^ b_v) & b_m) == '0)) begin
                c++;
                if (c == g) return k;
            end
        end
        return -1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each registered readback against the scoreboard.
    always @(posedge clk) rd_v <= rd_req;
    always @(negedge clk) begin
        if (rd_v) begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            check(cur_tag, 32'(rd_data), 32'(e));
        end
    end

    task automatic run_capture(string tag, int pre, int goal, logic [W-1:0] a_v, logic [W-1:0] a_m,
                               logic [W-1:0] b_v, logic [W-1:0] b_m, int arm_at);
        int kt, klast;
        kt = model_kt(pre, goal, a_v, a_m, b_v, b_m);
        klast = kt + D - pre - 1;
        pre_count = AW'(pre); occ_count = CW'(goal);
        va = a_v; ma = a_m; vb = b_v; mb = b_m;
        arm = 1'b1;
        @(negedge clk);
        for (int k = 0; k <= klast; k++) begin
            probe = f(k);
            arm = (k == arm_at);
            @(negedge clk);
            if (k == klast - 1) check({tag, " R8 done early"}, 32'(done), 32'd0);
            if (k == klast) begin
                check({tag, " R8 done"}, 32'(done), 32'd1);
                check({tag, " R10 trig_addr"}, 32'(trig_addr), 32'(kt % D));
            end
        end
        arm = 1'b0;
        // R12: probe keeps moving after done; the window must stay intact.
        cur_tag = {tag, " R9/R12 readback"};
        for (int i = 0; i < D; i++) begin
            probe = W'(16'hBEEF + i);
            rd_addr = AW'(i);
            rd_req = 1'b1;
            exp_q.push_back(f(kt - pre + i));
            @(negedge clk);
        end
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({tag, " R12 still done"}, 32'(state_o), 32'd4);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", 32'(done), 32'd0);
        check("R1 state after reset", 32'(state_o), 32'd0);
        // R2 R4: full mask single match, arm strobe during post-trigger ignored
        run_capture("T1 R2 R4", 4, 1, f(10), 16'hFFFF, 16'h0, 16'h0, 14);
        // R6: third occurrence of k%4==0 counted from k>=2
        run_capture("T2 R6", 2, 3, 16'h0000, 16'h0003, 16'h0, 16'h0, -1);
        // R5 R11: AND of two fields, no pre-trigger samples
        run_capture("T3 R5 R11", 0, 1, 16'h0005, 16'h000F, 16'h0020, 16'h00F0, -1);
        // R7: match at k=3 falls in pre-fill and is ignored
        run_capture("T4 R7", 8, 1, 16'h0003, 16'h0007, 16'h0, 16'h0, -1);
        // R11: maximum pre-trigger depth
        run_capture("T5 R11", D - 1, 1, f(20), 16'hFFFF, 16'h0, 16'h0, -1);
        // R6: occurrence count 0 behaves as 1; R3 restart from done
        run_capture("T6 R6 R3", 4, 0, f(10), 16'hFFFF, 16'h0, 16'h0, -1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule